// File: doc/BRIEF.md
# Output Data Queue with Diagnostic Register Drain

This block is a small first-in first-out queue of 16-bit words that sits in front of a bus output path. A producer pushes words in, and the bus engine takes them out in order through a one-cycle pop strobe while it watches the head word on a dedicated output. Full, empty and an occupancy count are always visible.

For test, a single enable bit lets software empty the queue through a register read port. The read names its byte lanes. A read that covers the low lane removes the head entry. A read of the high lane alone returns that half of the head word and leaves the queue untouched. When the enable is clear, the register port never removes anything. Any removal attempted on an empty queue changes nothing, returns zero and latches a sticky underflow indication until reset.

Top module: `outq_fifo`

## Requirements
- R1: While reset is asserted and just after it is released, empty is 1, full is 0, count is 0 and underflow is 0.
- R2: A push with the queue not full stores the word, and words leave in the order they were pushed. pop_data shows the oldest stored word.
- R3: A push while full is dropped: count stays at the depth and the stored words are not altered.
- R4: A pop strobe on a non-empty queue removes exactly one entry on the next clock edge.
- R5: With test_en=1, a register read with rd_lane=2'b11 (both lanes) returns the full head word on rd_data in the same cycle and removes one entry.
- R6: With test_en=1, a register read with rd_lane=2'b01 (low lane only) returns {8'h00, head[7:0]} and removes one entry.
- R7: With test_en=1, a register read with rd_lane=2'b10 (high lane only) returns {head[15:8], 8'h00} and does not remove any entry.
- R8: With test_en=0, or with rd_lane=2'b00, a register read returns zero and removes nothing.
- R9: A pop strobe or a removing register read on an empty queue returns zero on rd_data, leaves count at 0 and sets underflow. Underflow stays set until reset.
- R10: An accepted push and an accepted removal in the same cycle leave count unchanged.
- R11: A pop strobe and a removing register read in the same cycle remove only one entry, and the register read returns that entry.
- R12: full is 1 exactly when count equals the depth, and empty is 1 exactly when count is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| push_valid | input | 1 | Push request |
| push_data | input | DATA_W | Word to store |
| pop | input | 1 | Pop strobe from the bus engine |
| pop_data | output | DATA_W | Head word, zero when empty |
| test_en | input | 1 | Diagnostic drain enable |
| rd_en | input | 1 | Register read strobe |
| rd_lane | input | 2 | Byte lanes of the read: bit 0 low, bit 1 high |
| rd_data | output | DATA_W | Register read data, lane-masked |
| count | output | $clog2(DEPTH)+1 | Occupancy |
| full | output | 1 | Queue holds DEPTH words |
| empty | output | 1 | Queue holds no words |
| underflow | output | 1 | Sticky: removal attempted while empty |

## Verification
The bench builds the queue with its default parameters, DATA_W=16 and DEPTH=8. With eight entries the bench can fill the queue within a few pushes, test a push against the full boundary, and drain the queue again. The fill and drain also carry both pointers past their wrap point, so the extra pointer bit that tells full from empty gets exercised. The 16-bit width keeps the two byte lanes distinct, so every lane mask and every pop-or-peek decision shows up directly on rd_data.

// File: rtl/outq_pkg.sv
package outq_pkg;
  typedef enum logic [1:0] {
    LANE_NONE = 2'b00,
    LANE_LO   = 2'b01,
    LANE_HI   = 2'b10,
    LANE_WORD = 2'b11
  } lane_e;
endpackage

// File: rtl/outq_ptrs.sv
module outq_ptrs #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [PW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          underflow
);
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic          uf_q, uf_d;

  always_comb begin
    empty   = (wr_q == rd_q);
    full    = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
    push_ok = push_req & ~full;
    pop_ok  = pop_req & ~empty;
    wr_d    = wr_q + PW'(push_ok);
    rd_d    = rd_q + PW'(pop_ok);
    uf_d    = uf_q | (pop_req & empty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
      uf_q <= 1'b0;
    end else begin
      if (push_ok) wr_q <= wr_d;
      if (pop_ok)  rd_q <= rd_d;
      uf_q <= uf_d;
    end
  end

  assign wr_addr   = wr_q[AW-1:0];
  assign rd_addr   = rd_q[AW-1:0];
  assign count     = wr_q - rd_q;
  assign underflow = uf_q;
endmodule

// File: rtl/outq_store.sv
module outq_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic sel;
    assign sel = we && (waddr == AW'(i));
    always_ff @(posedge clk) begin
      if (sel) mem[i] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/outq_rdport.sv
module outq_rdport
  import outq_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int HALF = DATA_W / 2
) (
  input  logic              test_en,
  input  logic              rd_en,
  input  logic [1:0]        rd_lane,
  input  logic              empty,
  input  logic [DATA_W-1:0] head,
  output logic              reg_pop,
  output logic [DATA_W-1:0] rd_data
);
  logic  live;
  lane_e lane;

  always_comb begin
    lane    = lane_e'(rd_lane);
    live    = test_en & rd_en;
    reg_pop = live & ((lane == LANE_LO) || (lane == LANE_WORD));
    rd_data = '0;
    if (live && !empty) begin
      unique case (lane)
        LANE_WORD: rd_data = head;
        LANE_LO:   rd_data = {{(DATA_W-HALF){1'b0}}, head[HALF-1:0]};
        LANE_HI:   rd_data = {head[DATA_W-1:HALF], {HALF{1'b0}}};
        default:   rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/outq_fifo.sv
module outq_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  input  logic              test_en,
  input  logic              rd_en,
  input  logic [1:0]        rd_lane,
  output logic [DATA_W-1:0] rd_data,
  output logic [PW-1:0]     count,
  output logic              full,
  output logic              empty,
  output logic              underflow
);
  logic              push_ok, pop_ok, reg_pop, pop_req;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [DATA_W-1:0] head;

  assign pop_req = pop | reg_pop;

  outq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .push_req(push_valid), .pop_req(pop_req),
    .push_ok(push_ok), .pop_ok(pop_ok), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .count(count), .full(full), .empty(empty), .underflow(underflow)
  );

  outq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(push_ok), .waddr(wr_addr), .wdata(push_data),
    .raddr(rd_addr), .rdata(head)
  );

  outq_rdport #(.DATA_W(DATA_W)) u_rdport (
    .test_en(test_en), .rd_en(rd_en), .rd_lane(rd_lane), .empty(empty),
    .head(head), .reg_pop(reg_pop), .rd_data(rd_data)
  );

  assign pop_data = empty ? '0 : head;
endmodule

// File: rtl/outq_fifo_chk.sv
module outq_fifo_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int PW = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_valid,
  input logic              pop,
  input logic              test_en,
  input logic              rd_en,
  input logic [1:0]        rd_lane,
  input logic [DATA_W-1:0] rd_data,
  input logic [PW-1:0]     count,
  input logic              full,
  input logic              empty,
  input logic              underflow
);
  logic lo_read;
  assign lo_read = test_en && rd_en && rd_lane[0];

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !lo_read) |=> $stable(count));

  p_pop_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && pop && !push_valid) |=> (count == $past(count) - PW'(1)));

  p_high_peek_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && rd_en && rd_lane == 2'b10 && !pop && !push_valid) |=> $stable(count));

  p_idle_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_en) |-> (rd_data == '0));

  p_idle_no_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_en && !pop && !push_valid) |=> $stable(count));

  p_underflow_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && (pop || lo_read)) |=> underflow);

  p_underflow_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  p_push_pop_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !full && push_valid && (pop || lo_read)) |=> $stable(count));

  p_dual_pop_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && pop && lo_read && !push_valid) |=> (count == $past(count) - PW'(1)));

  p_flags_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (full == (count == PW'(DEPTH))) && (empty == (count == '0)));
endmodule

bind outq_fifo outq_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/outq_fifo_test.sv
module outq_fifo_test;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 8;
  localparam int PW     = $clog2(DEPTH) + 1;
  localparam int NV     = 10;

  logic              clk, rst_n;
  logic              push_valid, pop, test_en, rd_en;
  logic [DATA_W-1:0] push_data, pop_data, rd_data;
  logic [1:0]        rd_lane;
  logic [PW-1:0]     count;
  logic              full, empty, underflow;
  int                n_run, n_fail;

  outq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {push, data[15:0], pop, test_en, rd_en, lane[1:0], exp_rd[15:0], exp_cnt[3:0]}
  localparam logic [41:0] VECS [NV] = '{
    {1'b1, 16'hA1B2, 1'b0, 1'b0, 1'b0, 2'b00, 16'h0000, 4'd1}, // R2
    {1'b1, 16'hC3D4, 1'b0, 1'b0, 1'b0, 2'b00, 16'h0000, 4'd2}, // R2
    {1'b1, 16'hE5F6, 1'b0, 1'b0, 1'b0, 2'b00, 16'h0000, 4'd3}, // R2
    {1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 2'b10, 16'hA100, 4'd3}, // R7
    {1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 2'b01, 16'h00B2, 4'd2}, // R6
    {1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 2'b11, 16'hC3D4, 4'd1}, // R5
    {1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 2'b11, 16'h0000, 4'd1}, // R8
    {1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 2'b00, 16'h0000, 4'd1}, // R8
    {1'b1, 16'h1111, 1'b1, 1'b0, 1'b0, 2'b00, 16'h0000, 4'd1}, // R10
    {1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 2'b11, 16'h1111, 4'd0}  // R11
  };
  localparam string VTAG [NV] = '{"R2", "R2", "R2", "R7", "R6", "R5", "R8", "R8", "R10", "R11"};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    push_valid = 1'b0; push_data = '0; pop = 1'b0;
    test_en = 1'b0; rd_en = 1'b0; rd_lane = 2'b00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R1: values while reset is held
    check("R1 empty", 32'(empty), 1);
    check("R1 full", 32'(full), 0);
    check("R1 count", 32'(count), 0);
    check("R1 underflow", 32'(underflow), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 count after release", 32'(count), 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      {push_valid, push_data, pop, test_en, rd_en, rd_lane} = VECS[v][41:20];
      #2;
      check({VTAG[v], " rd_data"}, 32'(rd_data), 32'(VECS[v][19:4]));
      @(negedge clk);
      check({VTAG[v], " count"}, 32'(count), 32'(VECS[v][3:0]));
    end
    idle();

    // R9: removing read on empty queue
    test_en = 1'b1; rd_en = 1'b1; rd_lane = 2'b11;
    #2;
    check("R9 rd_data on empty", 32'(rd_data), 0);
    @(negedge clk);
    idle();
    check("R9 count", 32'(count), 0);
    check("R9 underflow set", 32'(underflow), 1);
    push_valid = 1'b1; push_data = 16'h7777;
    @(negedge clk);
    idle();
    check("R9 underflow sticky", 32'(underflow), 1);
    pop = 1'b1;
    @(negedge clk);
    idle();

    // R1: reset clears underflow
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 underflow cleared", 32'(underflow), 0);

    // fill to full, pointers wrap afterwards
    for (int i = 0; i < DEPTH; i++) begin
      push_valid = 1'b1; push_data = 16'h0100 + 16'(i);
      @(negedge clk);
    end
    idle();
    check("R12 full", 32'(full), 1);
    check("R12 count at depth", 32'(count), DEPTH);
    push_valid = 1'b1; push_data = 16'hDEAD;
    @(negedge clk);
    idle();
    check("R3 count after push while full", 32'(count), DEPTH);

    // drain through pop strobe, checking order
    for (int i = 0; i < DEPTH; i++) begin
      #2;
      check("R2 order", 32'(pop_data), 32'(16'h0100 + 16'(i)));
      pop = 1'b1;
      @(negedge clk);
      pop = 1'b0;
      check("R4 count after pop", 32'(count), DEPTH - 1 - i);
    end
    check("R12 empty", 32'(empty), 1);
    check("R3 no extra word", 32'(count), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule